// File: doc/BRIEF.md
# Mesh Dimension-Ordered Hop Router

This block makes the routing decision for one hop of a two-dimensional mesh. A head flit arrives with two signed offsets: the number of hops still to travel along X and along Y. The block picks exactly one of five exits (the local processor, or the East, West, North or South neighbour). It also rewrites the offsets so that the next switch sees the remaining distance.

The policy is fixed and deterministic. Any non-zero X offset is spent first, one hop at a time, each hop moving it one step toward zero. Only once X reaches zero does Y start to move, in the same way. When both offsets are zero the flit has arrived and leaves through the local port. Because a route never turns from Y back to X, every path uses channels in one fixed order, and the mesh cannot deadlock.

The decision and the rewritten header are registered. They appear one clock after the head flit is presented, and they hold steady while no flit is offered.

Top module: `dor_route_unit`

## Requirements
- R1: While reset is asserted and afterwards until the first valid head flit, `port_sel_o` is 5'b00000 and both offset outputs are zero.
- R2: A valid flit with a negative X offset selects West (`port_sel_o` = 5'b00100, bit 2). The X offset is forwarded increased by one and Y is forwarded unchanged.
- R3: A valid flit with a positive X offset selects East (5'b00010, bit 1). The X offset is forwarded decreased by one and Y is forwarded unchanged.
- R4: A valid flit with zero X offset and a negative Y offset selects South (5'b10000, bit 4). The Y offset is forwarded increased by one and X stays zero.
- R5: A valid flit with zero X offset and a positive Y offset selects North (5'b01000, bit 3). The Y offset is forwarded decreased by one and X stays zero.
- R6: A valid flit with both offsets zero selects Local (5'b00001, bit 0) and forwards zero offsets.
- R7: Whenever the X offset is non-zero, the Y offset is forwarded unchanged whatever its value. Feeding the outputs back hop by hop therefore gives all X moves, then all Y moves, then Local.
- R8: The port select and the rewritten offsets appear in the clock cycle after the valid head flit, together.
- R9: In the cycle after `hdr_valid_i` is low, `port_sel_o` is all zero and both offset outputs keep their previous values.
- R10: `port_sel_o` never has more than one bit set.
- R11: Offsets are 4-bit two's complement. The extreme values -8 and +7 route correctly, to -7 and +6, with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | A head flit is present this cycle |
| dx_i | input | 4 | Signed remaining X hops from the incoming header |
| dy_i | input | 4 | Signed remaining Y hops from the incoming header |
| port_sel_o | output | 5 | One-hot exit: bit0 Local, bit1 East, bit2 West, bit3 North, bit4 South |
| dx_o | output | 4 | Rewritten X offset for the outgoing header |
| dy_o | output | 4 | Rewritten Y offset for the outgoing header |

## Verification
The bench builds the block with its default offset width of four bits. At that width the whole signed range, including -8 and +7, can be reached directly from the vector table, so the extremes of R11 sit beside the ordinary cases. A directed multi-hop walk feeds each rewritten header back as the next input. This shows the X-before-Y order and the final Local delivery as a sequence, not as single decisions. Idle cycles between flits show that the offsets hold and that no exit is selected.

// File: rtl/dor_pkg.sv
package dor_pkg;

    localparam int NUM_PORTS = 5;
    localparam int OFF_W_DEF = 4;

    // exit bit positions inside the one-hot select
    localparam int P_LOCAL = 0;
    localparam int P_EAST  = 1;
    localparam int P_WEST  = 2;
    localparam int P_NORTH = 3;
    localparam int P_SOUTH = 4;

    typedef logic [NUM_PORTS-1:0] port_sel_t;

endpackage

// File: rtl/dor_port_decide.sv
module dor_port_decide
    import dor_pkg::*;
#(
    parameter int OFF_W = OFF_W_DEF
) (
    input  logic [OFF_W-1:0] dx,
    input  logic [OFF_W-1:0] dy,
    output port_sel_t        sel,
    output logic             step_x,
    output logic             step_y,
    output logic             x_up,
    output logic             y_up
);

    logic x_zero;
    logic y_zero;
    logic x_neg;
    logic y_neg;

    always_comb begin
        x_zero = (dx == '0);
        y_zero = (dy == '0);
        x_neg  = dx[OFF_W-1];
        y_neg  = dy[OFF_W-1];

        step_x = !x_zero;
        step_y = x_zero && !y_zero;
        x_up   = x_neg;
        y_up   = y_neg;

        sel = '0;
        if (!x_zero) begin
            if (x_neg) sel[P_WEST] = 1'b1;
            else       sel[P_EAST] = 1'b1;
        end else if (!y_zero) begin
            if (y_neg) sel[P_SOUTH] = 1'b1;
            else       sel[P_NORTH] = 1'b1;
        end else begin
            sel[P_LOCAL] = 1'b1;
        end
    end

endmodule

// File: rtl/dor_offset_step.sv
module dor_offset_step #(
    parameter int OFF_W = 4
) (
    input  logic [OFF_W-1:0] off,
    input  logic             en,
    input  logic             up,
    output logic [OFF_W-1:0] nxt
);

    localparam logic [OFF_W-1:0] ONE = OFF_W'(1);

    always_comb begin
        if (!en)     nxt = off;
        else if (up) nxt = off + ONE;
        else         nxt = off - ONE;
    end

endmodule

// File: rtl/dor_route_unit.sv
module dor_route_unit
    import dor_pkg::*;
#(
    parameter int OFF_W = OFF_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hdr_valid_i,
    input  logic signed [OFF_W-1:0] dx_i,
    input  logic signed [OFF_W-1:0] dy_i,
    output logic [NUM_PORTS-1:0]    port_sel_o,
    output logic signed [OFF_W-1:0] dx_o,
    output logic signed [OFF_W-1:0] dy_o
);

    localparam int AXES = 2;

    typedef struct packed {
        port_sel_t        sel;
        logic [OFF_W-1:0] dx;
        logic [OFF_W-1:0] dy;
    } route_state_t;

    route_state_t state_d;
    route_state_t state_q;

    port_sel_t        sel_w;
    logic [AXES-1:0]  step_w;
    logic [AXES-1:0]  up_w;
    logic [OFF_W-1:0] off_in  [AXES];
    logic [OFF_W-1:0] off_nxt [AXES];

    assign off_in[0] = dx_i;
    assign off_in[1] = dy_i;

    dor_port_decide #(.OFF_W(OFF_W)) u_decide (
        .dx     (dx_i),
        .dy     (dy_i),
        .sel    (sel_w),
        .step_x (step_w[0]),
        .step_y (step_w[1]),
        .x_up   (up_w[0]),
        .y_up   (up_w[1])
    );

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        dor_offset_step #(.OFF_W(OFF_W)) u_step (
            .off (off_in[a]),
            .en  (step_w[a]),
            .up  (up_w[a]),
            .nxt (off_nxt[a])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.sel = '0;
        if (hdr_valid_i) begin
            state_d.sel = sel_w;
            state_d.dx  = off_nxt[0];
            state_d.dy  = off_nxt[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign port_sel_o = state_q.sel;
    assign dx_o       = state_q.dx;
    assign dy_o       = state_q.dy;

endmodule

// File: rtl/dor_route_unit_chk.sv
module dor_route_unit_chk #(
    parameter int OFF_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    hdr_valid_i,
    input logic signed [OFF_W-1:0] dx_i,
    input logic signed [OFF_W-1:0] dy_i,
    input logic [4:0]              port_sel_o,
    input logic signed [OFF_W-1:0] dx_o,
    input logic signed [OFF_W-1:0] dy_o
);

    localparam logic [OFF_W-1:0] ONE = OFF_W'(1);

    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_sel_o));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid_i |=> (port_sel_o == 5'b00000) && $stable(dx_o) && $stable(dy_o));

    assert_west_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid_i && dx_i < 0) |=>
        (port_sel_o == 5'b00100) && (dx_o == $past(dx_i) + ONE) && (dy_o == $past(dy_i)));

    assert_east_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid_i && dx_i > 0) |=>
        (port_sel_o == 5'b00010) && (dx_o == $past(dx_i) - ONE) && (dy_o == $past(dy_i)));

    assert_south_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid_i && dx_i == 0 && dy_i < 0) |=>
        (port_sel_o == 5'b10000) && (dx_o == 0) && (dy_o == $past(dy_i) + ONE));

    assert_north_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid_i && dx_i == 0 && dy_i > 0) |=>
        (port_sel_o == 5'b01000) && (dx_o == 0) && (dy_o == $past(dy_i) - ONE));

    assert_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid_i && dx_i == 0 && dy_i == 0) |=>
        (port_sel_o == 5'b00001) && (dx_o == 0) && (dy_o == 0));

    assert_x_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid_i && dx_i != 0) |=> (dy_o == $past(dy_i)));

    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_i |=> (port_sel_o != 5'b00000));

endmodule

bind dor_route_unit dor_route_unit_chk #(.OFF_W(OFF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_valid_i (hdr_valid_i),
    .dx_i        (dx_i),
    .dy_i        (dy_i),
    .port_sel_o  (port_sel_o),
    .dx_o        (dx_o),
    .dy_o        (dy_o)
);

// File: tb/tb_dor_route_unit.sv
module tb_dor_route_unit;

    localparam int CLK_PERIOD = 10;
    localparam int W = 4;
    localparam int NVEC = 12;

    // {dx, dy, expected sel, expected dx, expected dy}
    localparam logic [20:0] VEC [NVEC] = '{
        {4'hD, 4'h2, 5'b00100, 4'hE, 4'h2},
        {4'h5, 4'hF, 5'b00010, 4'h4, 4'hF},
        {4'h0, 4'hC, 5'b10000, 4'h0, 4'hD},
        {4'h0, 4'h6, 5'b01000, 4'h0, 4'h5},
        {4'h0, 4'h0, 5'b00001, 4'h0, 4'h0},
        {4'h8, 4'h7, 5'b00100, 4'h9, 4'h7},
        {4'h7, 4'h8, 5'b00010, 4'h6, 4'h8},
        {4'h0, 4'h8, 5'b10000, 4'h0, 4'h9},
        {4'h0, 4'h7, 5'b01000, 4'h0, 4'h6},
        {4'h1, 4'h0, 5'b00010, 4'h0, 4'h0},
        {4'hF, 4'hF, 5'b00100, 4'h0, 4'hF},
        {4'h0, 4'h1, 5'b01000, 4'h0, 4'h0}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                hdr_valid_i = 1'b0;
    logic signed [W-1:0] dx_i = '0;
    logic signed [W-1:0] dy_i = '0;
    logic [4:0]          port_sel_o;
    logic signed [W-1:0] dx_o;
    logic signed [W-1:0] dy_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dor_route_unit #(.OFF_W(W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hdr_valid_i (hdr_valid_i),
        .dx_i        (dx_i),
        .dy_i        (dy_i),
        .port_sel_o  (port_sel_o),
        .dx_o        (dx_o),
        .dy_o        (dy_o)
    );

    function automatic string req_of(logic [W-1:0] dx, logic [W-1:0] dy);
        if ($signed(dx) < 0) return "R2";
        if ($signed(dx) > 0) return "R3";
        if ($signed(dy) < 0) return "R4";
        if ($signed(dy) > 0) return "R5";
        return "R6";
    endfunction

    task automatic check(string req, logic [4:0] es, logic [W-1:0] ex, logic [W-1:0] ey);
        checks++;
        if (port_sel_o !== es || dx_o !== ex || dy_o !== ey) begin
            errors++;
            $display("FAIL %s: sel=%b dx=%0d dy=%0d expected sel=%b dx=%0d dy=%0d",
                     req, port_sel_o, dx_o, dy_o, es, $signed(ex), $signed(ey));
        end
    endtask

    initial begin
        logic [4:0] hop_sel [6];
        hop_sel = '{5'b00010, 5'b00010, 5'b00010, 5'b10000, 5'b10000, 5'b00001};

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", 5'b0, '0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 5'b0, '0, '0);

        // table walk: R2..R6, R8, R11 (rows 6..9 are extremes)
        for (int i = 0; i < NVEC; i++) begin
            hdr_valid_i = 1'b1;
            dx_i = VEC[i][20:17];
            dy_i = VEC[i][16:13];
            @(negedge clk);
            check(i >= 5 && i <= 8 ? "R11" : req_of(VEC[i][20:17], VEC[i][16:13]),
                  VEC[i][12:8], VEC[i][7:4], VEC[i][3:0]);
        end

        // R9: idle cycle, no exit, offsets hold (last row left 0,0)
        hdr_valid_i = 1'b1;
        dx_i = 4'sd3;
        dy_i = -4'sd5;
        @(negedge clk);
        check("R3", 5'b00010, 4'd2, 4'hB);
        hdr_valid_i = 1'b0;
        dx_i = -4'sd6;
        dy_i = 4'sd6;
        @(negedge clk);
        check("R9", 5'b0, 4'd2, 4'hB);
        @(negedge clk);
        check("R9", 5'b0, 4'd2, 4'hB);

        // R7: X non-zero keeps Y even when Y is an extreme value
        hdr_valid_i = 1'b1;
        dx_i = -4'sd1;
        dy_i = -4'sd8;
        @(negedge clk);
        check("R7", 5'b00100, 4'd0, 4'h8);

        // R7: multi-hop walk from (+3,-2): E,E,E,S,S,Local
        dx_i = 4'sd3;
        dy_i = -4'sd2;
        for (int h = 0; h < 6; h++) begin
            logic [W-1:0] ex;
            logic [W-1:0] ey;
            ex = (h < 3) ? W'(2 - h) : '0;
            ey = (h < 3) ? 4'hE : (h == 3 ? 4'hF : 4'h0);
            @(negedge clk);
            check("R7", hop_sel[h], ex, ey);
            dx_i = dx_o;
            dy_i = dy_o;
        end
        hdr_valid_i = 1'b0;

        // R1: reset in mid-stream clears state
        hdr_valid_i = 1'b1;
        dx_i = 4'sd4;
        dy_i = 4'sd4;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", 5'b0, '0, '0);
        hdr_valid_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 5'b0, '0, '0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule